// File: doc/BRIEF.md
# Boot Image Checksum Verifier

This block decides whether a fixed 256-byte boot image may be executed. A loader presents the image one byte per clock, with a valid strobe. A start pulse opens each check. The first 252 bytes form the protected payload. Any unused part of that payload is zero-filled and still counts toward the checksum. The last four bytes carry the expected 32-bit CRC.

The CRC is a non-reflected, MSB-first variant of the common 32-bit polynomial. Its register is seeded with all ones, and no final inversion is applied. The block folds each payload byte into the CRC in a single cycle. It collects the four trailing bytes as a little-endian word and compares the two values when the last byte arrives.

The verdict is held steady until the next start pulse, so the loader can sample it at leisure. A start pulse that arrives in the middle of an image throws away the partial check and begins a new one.

Top module: `boot_crc_check`

## Requirements
- R1: While reset is asserted and after it is released, done_o and pass_o are both 0.
- R2: A cycle with start_i = 1 clears done_o and pass_o, visible after that clock edge, and readies the block to take byte 0 on the following accepted cycle. The byte on a start cycle is not taken.
- R3: The CRC covers bytes 0 to 251 with polynomial 0x04C11DB7. Each byte enters MSB first, with no bit reflection of inputs or result. The CRC register starts at 0xFFFFFFFF, and no final XOR is applied.
- R4: The stored checksum is bytes 252 to 255 in little-endian order: byte 252 is bits 7:0 and byte 255 is bits 31:24.
- R5: When the computed CRC differs from the stored checksum, done_o = 1 and pass_o = 0. pass_o is never 1 while done_o is 0.
- R6: done_o and pass_o update at the clock edge that accepts byte 255. They then hold, and further valid bytes leave them unchanged, until the next start pulse.
- R7: Cycles with valid_i = 0 are ignored whatever data_i carries, so gaps anywhere in the stream do not change the verdict.
- R8: A start pulse in the middle of an image abandons the partial check; the verdict then reflects only the bytes after that pulse.
- R9: Bytes presented after reset but before the first start pulse are ignored, and done_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a new check; aborts any check in progress |
| valid_i | input | 1 | data_i holds an image byte this cycle |
| data_i | input | 8 | Image byte |
| done_o | output | 1 | A full image has been received since the last start |
| pass_o | output | 1 | Computed CRC equals the stored checksum |

## Verification
Stimulus is driven on the falling edge, and each byte is taken at the next rising edge. The verdict is registered at the same rising edge that takes byte 255, so the bench samples done_o and pass_o at the falling edge right after the last byte. It also samples one falling edge before that, to confirm done_o is still low. The clearing effect of a start pulse is sampled at the falling edge after the start cycle's rising edge. The hold behaviour is checked by feeding extra bytes and sampling once they have all been clocked in.

// File: rtl/bcc_pkg.sv
package bcc_pkg;
  localparam int unsigned IMG_BYTES_DEF = 256;
  localparam int unsigned SUM_BYTES_DEF = 4;
  localparam int unsigned CRC_W_DEF     = 32;
  localparam logic [31:0] POLY_DEF      = 32'h04C1_1DB7;
  localparam logic [31:0] SEED_DEF      = 32'hFFFF_FFFF;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } bcc_state_e;
endpackage

// File: rtl/bcc_crc_step.sv
module bcc_crc_step #(
  parameter int unsigned W    = 32,
  parameter logic [W-1:0] POLY = 32'h04C1_1DB7
) (
  input  logic [W-1:0] crc_i,
  input  logic [7:0]   byte_i,
  output logic [W-1:0] crc_o
);
  // eight shift/xor steps unrolled, MSB of the byte first
  always_comb begin
    logic [W-1:0] c;
    c = crc_i;
    for (int k = 7; k >= 0; k--) begin
      if (c[W-1] ^ byte_i[k]) c = {c[W-2:0], 1'b0} ^ POLY;
      else                    c = {c[W-2:0], 1'b0};
    end
    crc_o = c;
  end
endmodule

// File: rtl/bcc_pos_counter.sv
module bcc_pos_counter #(
  parameter int unsigned LIMIT = 256,
  localparam int unsigned CW   = $clog2(LIMIT) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [CW-1:0] pos_o,
  output logic          last_o
);
  logic [CW-1:0] pos_q, pos_d;

  always_comb begin
    pos_d = pos_q;
    if (clr_i)      pos_d = '0;
    else if (inc_i) pos_d = pos_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_d;
  end

  assign pos_o  = pos_q;
  assign last_o = (pos_q == CW'(LIMIT - 1));

  // position never runs past the image end while counting (R6)
  p_pos_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (last_o && inc_i && !clr_i) |=> (pos_o == CW'(LIMIT)));
endmodule

// File: rtl/boot_crc_check.sv
module boot_crc_check
  import bcc_pkg::*;
#(
  parameter int unsigned IMG_BYTES = IMG_BYTES_DEF,
  parameter int unsigned SUM_BYTES = SUM_BYTES_DEF,
  parameter int unsigned CRC_W     = CRC_W_DEF,
  parameter logic [CRC_W-1:0] POLY = POLY_DEF,
  parameter logic [CRC_W-1:0] SEED = SEED_DEF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       valid_i,
  input  logic [7:0] data_i,
  output logic       done_o,
  output logic       pass_o
);
  localparam int unsigned PAY_BYTES = IMG_BYTES - SUM_BYTES;
  localparam int unsigned CW        = $clog2(IMG_BYTES) + 1;

  bcc_state_e     st_q, st_d;
  logic [CRC_W-1:0] crc_q, crc_d, crc_nx;
  logic [CRC_W-1:0] sig_q, sig_d, sig_full;
  logic           pass_q, pass_d;
  logic [CW-1:0]  pos;
  logic           last, accept, in_pay;

  assign accept   = valid_i && !start_i && (st_q == ST_RUN);
  assign in_pay   = (pos < CW'(PAY_BYTES));
  assign sig_full = {data_i, sig_q[CRC_W-1:8]};

  bcc_pos_counter #(.LIMIT(IMG_BYTES)) u_pos (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (start_i),
    .inc_i  (accept),
    .pos_o  (pos),
    .last_o (last)
  );

  bcc_crc_step #(.W(CRC_W), .POLY(POLY)) u_step (
    .crc_i  (crc_q),
    .byte_i (data_i),
    .crc_o  (crc_nx)
  );

  always_comb begin
    st_d   = st_q;
    crc_d  = crc_q;
    sig_d  = sig_q;
    pass_d = pass_q;
    if (start_i) begin
      st_d   = ST_RUN;
      crc_d  = SEED;
      sig_d  = '0;
      pass_d = 1'b0;
    end else if (accept) begin
      if (in_pay) crc_d = crc_nx;
      else        sig_d = sig_full;
      if (last) begin
        st_d   = ST_FIN;
        pass_d = (crc_q == sig_full);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      crc_q  <= '0;
      sig_q  <= '0;
      pass_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      crc_q  <= crc_d;
      sig_q  <= sig_d;
      pass_q <= pass_d;
    end
  end

  assign done_o = (st_q == ST_FIN);
  assign pass_o = pass_q;

  // pass only alongside done
  p_pass_needs_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pass_o |-> done_o);
  // start clears the verdict
  p_start_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (!done_o && !pass_o));
  // verdict holds until the next start
  p_verdict_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> (done_o && $stable(pass_o)));
  // done rises only on the last accepted byte
  p_done_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!done_o && !(valid_i && last && !start_i)) |=> !done_o);
  // idle block ignores data
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_IDLE) && !start_i) |=> ($stable(crc_q) && (st_q == ST_IDLE)));
  // gaps leave the CRC unchanged
  p_gap_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_i && !start_i) |=> $stable(crc_q));
endmodule

// File: tb/tb_boot_crc_check.sv
module tb_boot_crc_check;
  logic clk = 1'b0;
  logic rst_n, start_i, valid_i;
  logic [7:0] data_i;
  logic done_o, pass_o;
  int n_chk = 0, n_err = 0;
  logic [7:0] img [256];

  always #2 clk = ~clk;

  boot_crc_check dut (.clk(clk), .rst_n(rst_n), .start_i(start_i),
    .valid_i(valid_i), .data_i(data_i), .done_o(done_o), .pass_o(pass_o));

  function automatic logic [31:0] crc_of_img();
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < 252; i++)
      for (int b = 7; b >= 0; b--)
        c = (c[31] ^ img[i][b]) ? ({c[30:0], 1'b0} ^ 32'h04C1_1DB7) : {c[30:0], 1'b0};
    return c;
  endfunction

  function automatic logic exp_pass();
    return crc_of_img() == {img[255], img[254], img[253], img[252]};
  endfunction

  task automatic seal_le();
    logic [31:0] c = crc_of_img();
    img[252] = c[7:0]; img[253] = c[15:8]; img[254] = c[23:16]; img[255] = c[31:24];
  endtask

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start_i = 1'b1; valid_i = 1'($urandom); data_i = 8'($urandom);
    @(negedge clk);
    start_i = 1'b0; valid_i = 1'b0;
  endtask

  // sends bytes lo..hi; leaves at the negedge after the last byte was clocked
  task automatic send(input int lo, input int hi, input bit gaps);
    for (int i = lo; i <= hi; i++) begin
      if (gaps && ($urandom % 4 == 0)) begin
        valid_i = 1'b0; data_i = 8'($urandom);
        @(negedge clk);
      end
      valid_i = 1'b1; data_i = img[i];
      @(negedge clk);
    end
    valid_i = 1'b0;
  endtask

  task automatic rand_img(input int code_len);
    for (int i = 0; i < 252; i++) img[i] = (i < code_len) ? 8'($urandom) : 8'h00;
    seal_le();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [7:0] t;
    void'($urandom(32'd2024));
    rst_n = 1'b0; start_i = 1'b0; valid_i = 1'b0; data_i = 8'h00;
    repeat (3) @(negedge clk);
    chk(done_o === 1'b0 && pass_o === 1'b0, "R1 reset", {done_o, pass_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done_o === 1'b0 && pass_o === 1'b0, "R1 after release", {done_o, pass_o}, 0);

    // R9: stream before any start is ignored
    rand_img(252);
    send(0, 255, 1'b0);
    chk(done_o === 1'b0, "R9 no start", done_o, 0);

    // R3 R4 R6: good image, done exactly after byte 255
    pulse_start();
    send(0, 254, 1'b0);
    chk(done_o === 1'b0, "R6 before last", done_o, 0);
    send(255, 255, 1'b0);
    chk(done_o === 1'b1 && pass_o === 1'b1, "R3 good image", {done_o, pass_o}, 3);

    // R6: extra bytes do not disturb verdict
    for (int i = 0; i < 8; i++) img[i] = 8'($urandom);
    send(0, 7, 1'b1);
    chk(done_o === 1'b1 && pass_o === 1'b1, "R6 hold", {done_o, pass_o}, 3);

    // R2: start clears
    pulse_start();
    chk(done_o === 1'b0 && pass_o === 1'b0, "R2 clear", {done_o, pass_o}, 0);

    // R3: short code, zero-filled remainder
    rand_img(40);
    send(0, 255, 1'b0);
    chk(done_o === 1'b1 && pass_o === 1'b1, "R3 zero fill", {done_o, pass_o}, 3);

    // R5: corrupted payload byte
    pulse_start();
    rand_img(252);
    img[100] = img[100] ^ 8'h10;
    send(0, 255, 1'b0);
    chk(done_o === 1'b1 && pass_o === 1'b0, "R5 corrupt", {done_o, pass_o}, 2);

    // R4: checksum stored big-endian must fail
    pulse_start();
    rand_img(252);
    t = img[252]; img[252] = img[255]; img[255] = t;
    t = img[253]; img[253] = img[254]; img[254] = t;
    send(0, 255, 1'b0);
    chk(done_o === 1'b1 && pass_o === exp_pass(), "R4 byte order", {done_o, pass_o}, {1'b1, exp_pass()});

    // R3: inverted (final-XOR) checksum must fail
    pulse_start();
    rand_img(200);
    for (int i = 252; i < 256; i++) img[i] = ~img[i];
    send(0, 255, 1'b0);
    chk(done_o === 1'b1 && pass_o === 1'b0, "R3 no final xor", {done_o, pass_o}, 2);

    // R8: mid-stream restart
    pulse_start();
    rand_img(252);
    for (int i = 0; i < 252; i++) img[i] = ~img[i];
    send(0, 120, 1'b0);
    chk(done_o === 1'b0, "R8 partial", done_o, 0);
    pulse_start();
    rand_img(252);
    send(0, 255, 1'b1);
    chk(done_o === 1'b1 && pass_o === 1'b1, "R8 restart", {done_o, pass_o}, 3);

    // R7: random images with gaps, random corruption
    for (int n = 0; n < 8; n++) begin
      logic e;
      pulse_start();
      rand_img(int'($urandom % 253));
      if ($urandom % 2 == 1) img[$urandom % 256] ^= 8'(1 << ($urandom % 8));
      e = exp_pass();
      send(0, 255, 1'b1);
      chk(done_o === 1'b1 && pass_o === e, "R7 gaps random", {done_o, pass_o}, {1'b1, e});
    end

    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule